// File: doc/BRIEF.md
# Backlight Dimming PWM Generator

This block produces the dimming waveform for an LED backlight converter from a fast system clock. Software or a control block supplies a brightness request in whole percent and a repetition rate in hertz. Two control inputs affect the request: one selects stereoscopic (3D) operation, and the other marks that the backlight power-up sequence is running.

Before any request reaches the waveform engine, the block makes it legal. Duty values in the forbidden band just below full scale are pulled down to the band's lower edge. Full scale itself stays legal. Rates are kept inside the range the converter accepts. In 3D mode the user's dimming is ignored and the output runs at full brightness.

A divided-down tick drives a phase accumulator. The accumulator advances by the frequency setting on each tick and wraps once per output period. Settings are taken only at that wrap, and only when the power-up sequence is not running.

Top module: `bl_dim_pwm`

## Requirements
- R1: While reset is asserted and right after it, `pwm_out` is 0. Reset loads a duty setting of 0 % and a frequency setting of 180 Hz.
- R2: A frequency request below 95 is used as 95, and one above 200 is used as 200. Values from 95 to 200 are used unchanged. The unit is hertz of output period at the tick rate `TICK_HZ`.
- R3: The duty request is read as an unsigned percentage. Any value of 100 or above is used as 100.
- R4: A duty request of 98 or 99 is used as 97. A request of exactly 100 is kept as 100. No setting between 97 and 100, exclusive, is ever applied.
- R5: When `mode_3d` is 1 at a period start, the applied duty is 100 whatever `duty_req` holds.
- R6: Duty and frequency settings change only at a period start, which is a tick on which the accumulator wraps. Between period starts, request changes have no effect on the output.
- R7: While `seq_busy` is 1, period starts do not load new settings, and the previously applied settings stay in force.
- R8: With an applied duty of 100, `pwm_out` stays 1 with no low cycle. With an applied duty of 0, it stays 0.
- R9: On each tick, which is every `PRESCALE` clocks, the phase advances by the frequency setting modulo `TICK_HZ`. `pwm_out` is 1, one clock later, while the phase is below duty × `TICK_HZ`/100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| duty_req | input | 7 | Requested duty in percent |
| freq_req | input | 8 | Requested PWM rate in hertz |
| mode_3d | input | 1 | 1 selects 3D operation with forced full brightness |
| seq_busy | input | 1 | 1 while the backlight turn-on sequence is in progress |
| pwm_out | output | 1 | Dimming PWM waveform |

## Verification
The assertions assume that `mode_3d` and `seq_busy` are synchronous to `clk`, and that the requests may change on any cycle, including in the middle of a period. The bench drives every input on the falling edge and holds each pattern for many periods. It still changes requests at arbitrary points within a period, so the period-start rule is exercised. To keep the run short, the bench scales the tick rate down to 2000 and the prescaler to 2. The band, saturation and override values are not scaled.

// File: rtl/bl_dim_pwm_pkg.sv
package bl_dim_pwm_pkg;
  localparam int DUTY_W         = 7;
  localparam int FREQ_W         = 8;
  localparam int FREQ_LO        = 95;
  localparam int FREQ_HI        = 200;
  localparam int FREQ_NOM       = 180;
  localparam int DUTY_FULL      = 100;
  localparam int DUTY_BAND_CEIL = 97;

  typedef logic [DUTY_W-1:0] duty_t;
  typedef logic [FREQ_W-1:0] freq_t;
endpackage

// File: rtl/bl_req_cond.sv
module bl_req_cond
  import bl_dim_pwm_pkg::*;
(
  input  duty_t duty_in,
  input  freq_t freq_in,
  input  logic  mode_3d,
  output duty_t duty_out,
  output freq_t freq_out
);
  // duty: 3D override, saturation to full scale, forbidden band folded down
  always_comb begin
    if (mode_3d || (int'(duty_in) >= DUTY_FULL))
      duty_out = DUTY_W'(DUTY_FULL);
    else if (int'(duty_in) > DUTY_BAND_CEIL)
      duty_out = DUTY_W'(DUTY_BAND_CEIL);
    else
      duty_out = duty_in;
  end

  // rate: clamp to the accepted range
  always_comb begin
    if (int'(freq_in) < FREQ_LO)
      freq_out = FREQ_W'(FREQ_LO);
    else if (int'(freq_in) > FREQ_HI)
      freq_out = FREQ_W'(FREQ_HI);
    else
      freq_out = freq_in;
  end
endmodule

// File: rtl/bl_tick_gen.sv
module bl_tick_gen #(
  parameter int PRESCALE = 12500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CNT_LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bl_pwm_phase.sv
module bl_pwm_phase
  import bl_dim_pwm_pkg::*;
#(
  parameter int TICK_HZ = 20000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  duty_t duty_q,
  input  freq_t freq_q,
  output logic  wrap,
  output logic  pwm_q
);
  localparam int ACC_W = $clog2(TICK_HZ + (1 << FREQ_W));
  localparam int STEP  = TICK_HZ / DUTY_FULL;
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc_q, acc_d, sum, thr;
  logic             pwm_d;

  always_comb begin
    sum   = acc_q + ACC_W'(freq_q);
    wrap  = tick && (sum >= MODULUS);
    acc_d = (sum >= MODULUS) ? (sum - MODULUS) : sum;
    thr   = ACC_W'(duty_q) * ACC_W'(STEP);
    pwm_d = (acc_q < thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (tick) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end
endmodule

// File: rtl/bl_dim_pwm.sv
module bl_dim_pwm
  import bl_dim_pwm_pkg::*;
#(
  parameter int PRESCALE = 12500,
  parameter int TICK_HZ  = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] duty_req,
  input  logic [7:0] freq_req,
  input  logic       mode_3d,
  input  logic       seq_busy,
  output logic       pwm_out
);
  duty_t duty_c, duty_q;
  freq_t freq_c, freq_q;
  logic  tick, wrap, load_en;

  bl_req_cond u_cond (
    .duty_in (duty_req),
    .freq_in (freq_req),
    .mode_3d (mode_3d),
    .duty_out(duty_c),
    .freq_out(freq_c)
  );

  bl_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  assign load_en = wrap && !seq_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      freq_q <= FREQ_W'(FREQ_NOM);
    end else if (load_en) begin
      duty_q <= duty_c;
      freq_q <= freq_c;
    end
  end

  bl_pwm_phase #(.TICK_HZ(TICK_HZ)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .duty_q(duty_q),
    .freq_q(freq_q),
    .wrap  (wrap),
    .pwm_q (pwm_out)
  );
endmodule

// File: rtl/bl_dim_pwm_chk.sv
module bl_dim_pwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_3d,
  input logic       seq_busy,
  input logic       wrap,
  input logic [6:0] duty_q,
  input logic [7:0] freq_q,
  input logic       pwm_out
);
  AST_FREQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_q >= 8'd95) && (freq_q <= 8'd200)); // R2
  AST_DUTY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q <= 7'd97) || (duty_q == 7'd100)); // R4
  AST_DUTY_3D_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_3d && wrap && !seq_busy) |=> (duty_q == 7'd100)); // R5
  AST_DUTY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> $past(wrap)); // R6
  AST_FREQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_q) |-> $past(wrap)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_busy) |-> ($stable(duty_q) && $stable(freq_q))); // R7
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(duty_q) == 7'd100) |-> pwm_out); // R8
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(duty_q) == 7'd0) |-> !pwm_out); // R8
endmodule

bind bl_dim_pwm bl_dim_pwm_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode_3d (mode_3d),
  .seq_busy(seq_busy),
  .wrap    (wrap),
  .duty_q  (duty_q),
  .freq_q  (freq_q),
  .pwm_out (pwm_out)
);

// File: tb/bl_dim_pwm_tb_top.sv
`timescale 1ns/1ps
module bl_dim_pwm_tb_top;
  localparam int PRESCALE = 2;
  localparam int TICK_HZ  = 2000;
  localparam int STEP     = TICK_HZ / 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] duty_req;
  logic [7:0] freq_req;
  logic       mode_3d;
  logic       seq_busy;
  logic       pwm_out;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // reference model state
  int pre_m, acc_m, duty_m, freq_m;
  bit pwm_m;

  always #2 clk = ~clk;

  bl_dim_pwm #(.PRESCALE(PRESCALE), .TICK_HZ(TICK_HZ)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty_req(duty_req),
    .freq_req(freq_req),
    .mode_3d (mode_3d),
    .seq_busy(seq_busy),
    .pwm_out (pwm_out)
  );

  function automatic int legal_duty(int d, bit m3);
    if (m3 || d >= 100) return 100;   // R5, R3
    if (d > 97) return 97;            // R4
    return d;
  endfunction

  function automatic int legal_freq(int f);
    if (f < 95) return 95;            // R2
    if (f > 200) return 200;
    return f;
  endfunction

  // behavioural model: R1, R6, R7, R9
  always @(posedge clk) begin
    if (!rst_n) begin
      pre_m = 0; acc_m = 0; duty_m = 0; freq_m = 180; pwm_m = 1'b0;
    end else begin
      pwm_m = (acc_m < duty_m * STEP);
      if (pre_m == PRESCALE - 1) begin
        pre_m = 0;
        acc_m = acc_m + freq_m;
        if (acc_m >= TICK_HZ) begin
          acc_m = acc_m - TICK_HZ;
          if (!seq_busy) begin
            duty_m = legal_duty(int'(duty_req), mode_3d);
            freq_m = legal_freq(int'(freq_req));
          end
        end
      end else begin
        pre_m = pre_m + 1;
      end
    end
  end

  task automatic check(string req, bit act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pwm_out actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(tag, pwm_out, pwm_m);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(int d, int f, bit m3, bit busy);
    duty_req = 7'(d); freq_req = 8'(f); mode_3d = m3; seq_busy = busy;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(50, 180, 1'b0, 1'b0);
    run(3);
    check("R1", pwm_out, 1'b0);              // R1 output low in reset
    rst_n = 1'b1;
    tag = "R1"; run(60);                     // default 0 % at 180 Hz
    tag = "R9"; drive(50, 180, 0, 0); run(300);
    tag = "R6"; drive(30, 120, 0, 0); run(7); drive(70, 150, 0, 0); run(300);
    tag = "R2"; drive(25, 95, 0, 0);  run(250);
    drive(75, 200, 0, 0); run(250);
    drive(40, 20, 0, 0);  run(250);
    drive(60, 255, 0, 0); run(250);
    tag = "R4"; drive(98, 150, 0, 0); run(250);
    drive(99, 180, 0, 0); run(250);
    drive(97, 180, 0, 0); run(250);
    tag = "R8"; drive(100, 180, 0, 0); run(250);
    for (int i = 0; i < 50; i++) begin
      check("R8", pwm_out, 1'b1); run(1);    // full scale: never low
    end
    drive(0, 180, 0, 0); run(250);
    for (int i = 0; i < 50; i++) begin
      check("R8", pwm_out, 1'b0); run(1);    // zero: never high
    end
    tag = "R3"; drive(120, 130, 0, 0); run(250);
    tag = "R5"; drive(10, 180, 1, 0); run(250);
    for (int i = 0; i < 50; i++) begin
      check("R5", pwm_out, 1'b1); run(1);    // 3D forces full brightness
    end
    tag = "R7"; drive(50, 180, 0, 0); run(250);
    drive(5, 100, 1, 1); run(400);           // requests ignored while busy
    drive(5, 100, 0, 0); run(300);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule